// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of an Ethernet receive path and decides, per frame, whether the frame is kept. It watches the destination address as it arrives, one byte per accepted beat, starting at a beat flagged as start-of-frame. While the six address bytes go by it stores them and runs a CRC-32 over them. When the sixth byte lands it classifies the address and produces a one-cycle verdict. The address falls into one of three classes: the all-ones broadcast address, a group (multicast) address, or an individual (unicast) address.

The verdict combines the address class with a small configuration: a six-byte station address, a 64-bit multicast hash table and five acceptance-mode bits. All of these are written through a simple 16-bit register write port. The receive logic downstream uses the verdict to keep or drop the rest of the frame; payload, frame check sequence and buffering are handled elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the station address, hash table and mode bits are all zero, no decision is signalled until a frame's sixth address byte arrives, and every frame is then rejected.
- R2: A write with `cfg_addr` 0..5 loads station byte 0..5 from `cfg_wdata[7:0]` (byte 0 is the first byte on the wire). Addresses 8..11 load table bits [15:0], [31:16], [47:32] and [63:48]. Address 12 loads the mode from `cfg_wdata[4:0]`. Other addresses change nothing.
- R3: `decision_valid` is high for exactly one cycle, in the cycle after the clock edge that samples the sixth address byte of a frame.
- R4: A beat with `byte_valid` and `sof` high is byte 0 of a new frame and discards any partial address. Beats before the first start-of-frame and beats after the sixth byte produce no decision.
- R5: Mode bit 4 (promiscuous) accepts every frame, whatever the other bits hold.
- R6: The all-ones address is accepted, outside promiscuous mode, only when mode bit 0 (broadcast) is set; the all-multicast and hash settings do not accept it.
- R7: An address with bit 0 of byte 0 clear is accepted, outside promiscuous mode, only when it equals the station address and mode bit 1 (unicast) is set.
- R8: A group address other than broadcast is accepted when mode bit 3 (all-multicast) is set.
- R9: With mode bit 2 (hash) set, a group address other than broadcast is accepted when table bit h is 1. Here h is the low six bits of a CRC-32 (polynomial 0x04C11DB7, register preset to all ones, each byte fed least significant bit first, result neither reflected nor inverted) taken over the six bytes in wire order.
- R10: `accept` is low in every cycle where `decision_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | An address byte is present on `byte_data` this cycle |
| sof | input | 1 | With `byte_valid`, marks byte 0 of a frame |
| byte_data | input | 8 | Received byte |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| decision_valid | output | 1 | One-cycle strobe carrying the verdict |
| accept | output | 1 | Frame is kept when high together with `decision_valid` |

## Verification
The checker watches the verdict strobe on every cycle: it must be a single-cycle pulse, it must follow a received byte, `accept` may never stand alone, promiscuous mode must always accept, and an all-zero mode must always reject. The CRC index, the placement of table bits across the four registers, the split between broadcast, station and group addresses, and restart on a fresh start-of-frame can only be shown by the bench. It sweeps every table bit against a set of group addresses and every mode combination against each address class, and compares the results with values it computes itself.

// File: rtl/addr_filt_pkg.sv
// Shared types and constants for the receive address filter.
package addr_filt_pkg;

    // Acceptance mode bits; bit 0 is broadcast, bit 4 is promiscuous.
    typedef struct packed {
        logic promisc;
        logic allmulti;
        logic hash_en;
        logic uc_en;
        logic bc_en;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    // Configuration register select values.
    localparam logic [3:0] CFG_STA_BASE  = 4'd0;
    localparam logic [3:0] CFG_HASH_BASE = 4'd8;
    localparam logic [3:0] CFG_MODE      = 4'd12;

    // Address class of a received destination.
    typedef enum logic [1:0] {
        CLS_UNICAST = 2'd0,
        CLS_GROUP   = 2'd1,
        CLS_BCAST   = 2'd2
    } addr_class_e;

endpackage

// File: rtl/addr_filt_crc_step.sv
// One byte of a big-endian CRC: eight shift stages, data taken LSB first.
// Assumes a purely combinational use; no state.
module addr_filt_crc_step #(
    parameter int          CRC_W = 32,
    parameter logic [31:0] POLY  = 32'h04C1_1DB7
) (
    input  logic [CRC_W-1:0] crc_i,
    input  logic [7:0]       data_i,
    output logic [CRC_W-1:0] crc_o
);
    logic [8:0][CRC_W-1:0] stage;

    assign stage[0] = crc_i;

    // One shift-and-conditional-xor stage per data bit.
    for (genvar g = 0; g < 8; g++) begin : g_bit
        logic fb;
        assign fb           = stage[g][CRC_W-1] ^ data_i[g];
        assign stage[g+1]   = {stage[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
    end

    assign crc_o = stage[8];
endmodule

// File: rtl/addr_filt_cfg.sv
// Configuration registers: station address bytes, hash table words, mode.
// Assumes a single write port; reads are direct wire outputs.
module addr_filt_cfg
    import addr_filt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    parameter int REG_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [3:0]                    cfg_addr,
    input  logic [REG_W-1:0]              cfg_wdata,
    output logic [ADDR_BYTES-1:0][7:0]    station_o,
    output logic [(1<<HASH_BITS)-1:0]     table_o,
    output mode_t                         mode_o
);
    localparam int TBL_W  = 1 << HASH_BITS;
    localparam int TBL_RG = TBL_W / REG_W;

    logic [ADDR_BYTES-1:0][7:0] sta_q;
    logic [TBL_RG-1:0][REG_W-1:0] tbl_q;
    mode_t mode_q;

    // Station address bytes, one register per byte.
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_sta
        always_ff @(posedge clk) begin : p_sta
            if (!rst_n)
                sta_q[b] <= '0;
            else if (cfg_wr && cfg_addr == CFG_STA_BASE + 4'(b))
                sta_q[b] <= cfg_wdata[7:0];
        end
    end

    // Hash table words, lowest word holds the lowest table bits.
    for (genvar r = 0; r < TBL_RG; r++) begin : g_tbl
        always_ff @(posedge clk) begin : p_tbl
            if (!rst_n)
                tbl_q[r] <= '0;
            else if (cfg_wr && cfg_addr == CFG_HASH_BASE + 4'(r))
                tbl_q[r] <= cfg_wdata;
        end
    end

    // Acceptance mode bits.
    always_ff @(posedge clk) begin : p_mode
        if (!rst_n)
            mode_q <= '0;
        else if (cfg_wr && cfg_addr == CFG_MODE)
            mode_q <= mode_t'(cfg_wdata[MODE_W-1:0]);
    end

    assign station_o = sta_q;
    assign table_o   = tbl_q;
    assign mode_o    = mode_q;
endmodule

// File: rtl/addr_filt_collect.sv
// Gathers the destination address bytes after start-of-frame and runs the
// CRC alongside. Flags the beat carrying the last address byte and presents
// the complete address and CRC combinationally on that beat.
module addr_filt_collect #(
    parameter int          ADDR_BYTES = 6,
    parameter int          CRC_W      = 32,
    parameter logic [31:0] POLY       = 32'h04C1_1DB7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_valid,
    input  logic                       sof,
    input  logic [7:0]                 byte_data,
    output logic                       done_o,
    output logic [ADDR_BYTES-1:0][7:0] addr_o,
    output logic [CRC_W-1:0]           crc_o
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);

    logic [CNT_W-1:0]           cnt_q;
    logic                       active_q;
    logic [ADDR_BYTES-1:0][7:0] addr_q;
    logic [CRC_W-1:0]           crc_q;
    logic [CRC_W-1:0]           crc_in;
    logic [CRC_W-1:0]           crc_nx;
    logic [CNT_W-1:0]           slot;
    logic                       take;

    // Which byte slot this beat fills, and whether it is taken at all.
    always_comb begin : p_slot
        if (sof) begin
            slot   = '0;
            crc_in = '1;
        end else begin
            slot   = cnt_q;
            crc_in = crc_q;
        end
        take = byte_valid && (sof || active_q);
    end

    addr_filt_crc_step #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
        .crc_i  (crc_in),
        .data_i (byte_data),
        .crc_o  (crc_nx)
    );

    // Byte counter and frame-active flag.
    always_ff @(posedge clk) begin : p_cnt
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (take) begin
            cnt_q    <= slot + 1'b1;
            active_q <= (slot != CNT_W'(ADDR_BYTES - 1));
        end
    end

    // Running CRC register.
    always_ff @(posedge clk) begin : p_crc
        if (!rst_n)
            crc_q <= '1;
        else if (take)
            crc_q <= crc_nx;
    end

    // Address byte storage.
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_addr
        always_ff @(posedge clk) begin : p_addr
            if (!rst_n)
                addr_q[b] <= '0;
            else if (take && slot == CNT_W'(b))
                addr_q[b] <= byte_data;
        end
    end

    // Full address including the byte on the current beat.
    always_comb begin : p_full
        addr_o = addr_q;
        for (int b = 0; b < ADDR_BYTES; b++)
            if (slot == CNT_W'(b))
                addr_o[b] = byte_data;
    end

    assign done_o = take && (slot == CNT_W'(ADDR_BYTES - 1));
    assign crc_o  = crc_nx;
endmodule

// File: rtl/addr_filt_decide.sv
// Classifies a complete address and registers the keep/drop verdict.
// Assumes done_i is high only on the beat carrying the last address byte.
module addr_filt_decide
    import addr_filt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    parameter int CRC_W      = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       done_i,
    input  logic [ADDR_BYTES-1:0][7:0] addr_i,
    input  logic [CRC_W-1:0]           crc_i,
    input  logic [ADDR_BYTES-1:0][7:0] station_i,
    input  logic [(1<<HASH_BITS)-1:0]  table_i,
    input  mode_t                      mode_i,
    output logic                       valid_o,
    output logic                       accept_o
);
    addr_class_e        cls;
    logic [HASH_BITS-1:0] idx;
    logic               hit_tbl;
    logic               hit_sta;
    logic               keep;

    // Address class and lookups.
    always_comb begin : p_class
        if (&addr_i)
            cls = CLS_BCAST;
        else if (addr_i[0][0])
            cls = CLS_GROUP;
        else
            cls = CLS_UNICAST;
        idx     = crc_i[HASH_BITS-1:0];
        hit_tbl = table_i[idx];
        hit_sta = (addr_i == station_i);
    end

    // Verdict from class and mode.
    always_comb begin : p_keep
        keep = 1'b0;
        if (mode_i.promisc)
            keep = 1'b1;
        else begin
            unique case (cls)
                CLS_BCAST:   keep = mode_i.bc_en;
                CLS_GROUP:   keep = mode_i.allmulti || (mode_i.hash_en && hit_tbl);
                default:     keep = mode_i.uc_en && hit_sta;
            endcase
        end
    end

    // Registered one-cycle verdict.
    always_ff @(posedge clk) begin : p_out
        if (!rst_n) begin
            valid_o  <= 1'b0;
            accept_o <= 1'b0;
        end else begin
            valid_o  <= done_i;
            accept_o <= done_i && keep;
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination address filter top. Collects six address bytes after
// start-of-frame, hashes them, and emits a one-cycle accept/reject verdict.
// Assumes configuration writes and frames may overlap; the verdict uses the
// configuration present on the beat of the last address byte.
module rx_addr_filter
    import addr_filt_pkg::*;
#(
    parameter int          ADDR_BYTES = 6,
    parameter int          HASH_BITS  = 6,
    parameter int          REG_W      = 16,
    parameter int          CRC_W      = 32,
    parameter logic [31:0] POLY       = 32'h04C1_1DB7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             sof,
    input  logic [7:0]       byte_data,
    input  logic             cfg_wr,
    input  logic [3:0]       cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic             decision_valid,
    output logic             accept
);
    localparam int TBL_W = 1 << HASH_BITS;

    logic [ADDR_BYTES-1:0][7:0] station_w;
    logic [TBL_W-1:0]           table_w;
    mode_t                      mode_w;
    logic                       done_w;
    logic [ADDR_BYTES-1:0][7:0] addr_w;
    logic [CRC_W-1:0]           crc_w;

    addr_filt_cfg #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS), .REG_W(REG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .station_o (station_w),
        .table_o   (table_w),
        .mode_o    (mode_w)
    );

    addr_filt_collect #(.ADDR_BYTES(ADDR_BYTES), .CRC_W(CRC_W), .POLY(POLY)) u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .sof        (sof),
        .byte_data  (byte_data),
        .done_o     (done_w),
        .addr_o     (addr_w),
        .crc_o      (crc_w)
    );

    addr_filt_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS), .CRC_W(CRC_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done_w),
        .addr_i    (addr_w),
        .crc_i     (crc_w),
        .station_i (station_w),
        .table_i   (table_w),
        .mode_i    (mode_w),
        .valid_o   (decision_valid),
        .accept_o  (accept)
    );
endmodule

// File: rtl/addr_filt_chk.sv
// Protocol checker for rx_addr_filter, attached by bind below.
// Observes the ports and the mode register held in the configuration block.
module addr_filt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic       decision_valid,
    input logic       accept,
    input logic [4:0] mode
);
    // R3: the verdict strobe never lasts two cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |=> !decision_valid);

    // R3: a verdict always follows a received byte
    a_r3_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |-> $past(byte_valid));

    // R10: accept never appears without the strobe
    a_r10_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> decision_valid);

    // R5: promiscuous mode keeps every frame
    a_r5_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && $past(mode[4])) |-> accept);

    // R1: an all-zero mode keeps nothing
    a_r1_zero_mode_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && $past(mode) == 5'd0) |-> !accept);
endmodule

bind rx_addr_filter addr_filt_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .byte_valid     (byte_valid),
    .decision_valid (decision_valid),
    .accept         (accept),
    .mode           (mode_w)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic        sof = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        decision_valid;
    logic        accept;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Bench-side copy of the programmed configuration.
    logic [47:0] m_sta = '0;
    logic [63:0] m_tbl = '0;
    logic [4:0]  m_mode = '0;

    rx_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .sof(sof),
        .byte_data(byte_data), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .decision_valid(decision_valid), .accept(accept)
    );

    always #2.5 clk = ~clk;

    // CRC per R9: preset ones, LSB first, MSB-side feedback.
    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[31] ^ a[i];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return c;
    endfunction

    // Expected verdict from R5..R9.
    function automatic logic ref_keep(input logic [47:0] a);
        if (m_mode[4]) return 1'b1;
        if (&a) return m_mode[0];
        if (a[0]) return m_mode[3] || (m_mode[2] && m_tbl[ref_crc(a) & 32'h3F]);
        return m_mode[1] && (a == m_sta);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a < 6) m_sta[8*a +: 8] = d[7:0];
        else if (a >= 8 && a < 12) m_tbl[16*(a-8) +: 16] = d;
        else if (a == 12) m_mode = d[4:0];
    endtask

    task automatic set_station(input logic [47:0] s);
        for (int i = 0; i < 6; i++) cfg(4'(i), {8'h00, s[8*i +: 8]});
    endtask

    task automatic set_table(input logic [63:0] t);
        for (int i = 0; i < 4; i++) cfg(4'(8 + i), t[16*i +: 16]);
    endtask

    // Drive six bytes, check no early strobe, then the verdict (R3).
    task automatic frame(input string req, input logic [47:0] a, input logic exp);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i > 0) check("R3 early", decision_valid, 1'b0);
            byte_valid = 1'b1; sof = (i == 0); byte_data = a[8*i +: 8];
        end
        @(negedge clk);
        byte_valid = 1'b0; sof = 1'b0;
        check("R3 strobe", decision_valid, 1'b1);
        check(req, accept, exp);
        @(negedge clk);
        check("R3 width", decision_valid, 1'b0);
        check("R10 accept low", accept, 1'b0);
    endtask

    task automatic frame_ref(input string req, input logic [47:0] a);
        frame(req, a, ref_keep(a));
    endtask

    localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] STA  = 48'h5544_3322_1102;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset, everything rejected
        check("R1 valid idle", decision_valid, 1'b0);
        check("R1 accept idle", accept, 1'b0);
        frame("R1 bcast rejected", BC, 1'b0);
        frame("R1 unicast rejected", 48'h0, 1'b0);
        frame("R1 group rejected", 48'h0000_5E00_0001, 1'b0);

        // R4: bytes before any start-of-frame are ignored
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); byte_valid = 1'b1; sof = 1'b0; byte_data = 8'(i);
            check("R4 no sof", decision_valid, 1'b0);
        end
        @(negedge clk); byte_valid = 1'b0;
        check("R4 no sof", decision_valid, 1'b0);

        // R2: unused address writes leave the mode untouched
        cfg(4'd13, 16'h001F);
        cfg(4'd7, 16'hFFFF);
        m_mode = '0;
        frame("R2 unused addr", BC, 1'b0);

        // R5..R8: every mode against each address class
        set_station(STA);
        set_table(64'hA5C3_0F96_3C5A_F00F);
        for (int m = 0; m < 32; m++) begin
            cfg(4'd12, 16'(m));
            frame_ref("R6 broadcast", BC);
            frame_ref("R7 station match", STA);
            frame_ref("R7 station miss", STA ^ 48'h0100_0000_0000);
            frame_ref("R7 near broadcast unicast", 48'hFFFF_FFFF_FFFE);
            frame_ref("R8 group", 48'h3412_005E_0001);
            frame_ref("R8 group", 48'h0000_0000_0033);
            frame_ref("R5 promisc unicast", 48'h0A0B_0C0D_0E10);
        end

        // R9 and R2 table placement: one table bit at a time
        cfg(4'd12, 16'h0004);
        for (int b = 0; b < 64; b++) begin
            set_table(64'd1 << b);
            for (int k = 0; k < 24; k++) begin
                logic [47:0] a;
                a = {8'h07, 8'(k * 37), 8'(k), 8'h5E, 8'h00, 8'h01};
                frame("R9 hash index", a, (ref_crc(a) & 32'h3F) == 32'(b));
            end
        end

        // R4: partial address abandoned by a new start-of-frame
        set_table('0);
        cfg(4'd12, 16'h0002);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); byte_valid = 1'b1; sof = (i == 0); byte_data = 8'hEE;
        end
        frame("R4 restart keeps new frame", STA, 1'b1);
        // R4: extra bytes after the sixth produce no verdict
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); byte_valid = 1'b1; sof = 1'b0; byte_data = STA[8*i +: 8];
            check("R4 trailing bytes", decision_valid, 1'b0);
        end
        @(negedge clk); byte_valid = 1'b0;
        check("R4 trailing bytes", decision_valid, 1'b0);
        @(negedge clk);
        check("R4 trailing bytes", decision_valid, 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule